// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Switch Fabric

This block is an unbuffered multistage packet fabric for N = 2^LOG_N ports, with eight ports by default. In every clock cycle each input may present one packet, which is a valid flag, a destination port number and a payload. The fabric carries each packet through LOG_N registered stages of two-by-two steering elements. Each stage accepts a fresh set of N packets every cycle.

Routing is local. The destination is bit-reversed into a routing tag. The element in stage s looks only at bit s of that tag and sends the packet to its upper output for 0 or to its lower output for 1. Perfect-shuffle wiring joins the stages, and it also sits ahead of the first stage. Each source and destination pair therefore has exactly one path. No queue exists anywhere in the fabric. When two packets at one element ask for the same output, the packet on the upper element input goes on and the other packet is discarded. The discarded packet is reported on a drop line that is indexed by the input port where it entered.

Each output port shows its valid flag, its payload and the original destination field. The drop vector is aligned with the output slot of the same injection cycle. The logic around the fabric uses it to count losses or to retry.

Top module: `shuffle_fabric`

## Requirements
- R1: While reset is low, and on the first cycle after it, out_valid and out_drop are all zero. Packets that were inside the pipeline when reset arrived never appear afterwards.
- R2: A packet sampled at clock edge t is presented on the outputs after edge t+LOG_N. A new set of N packets can be injected on every cycle.
- R3: A delivered packet appears only on the output port whose index equals its destination field. Its destination field and payload arrive unchanged.
- R4: Stage input position p is fed by line rotr(p) of the previous stage, where rotr is a one-bit right rotation of a LOG_N-bit index. Stage 0 is fed from the input ports in the same way. Element e owns positions 2e (upper) and 2e+1 (lower). At stage s (the first stage is 0) the steering bit is destination bit LOG_N-1-s. For N=8, input 0 to port 0 together with input 2 to port 1 collide in stage 1, so only port 0 is delivered.
- R5: A single packet injected alone, from any input to any destination, is always delivered and never dropped.
- R6: When both packets at an element request the same output, the packet on the upper position wins. For N=8 with all inputs sent to port 0, the packet from input 0 is delivered and every other input is dropped.
- R7: A discarded packet sets out_drop[i], where i is its original input port. This bit appears in the same cycle in which its slot's outputs appear. out_drop is never set for a port that did not inject in that slot.
- R8: For every slot, the count of set out_valid bits plus the count of set out_drop bits equals the count of set in_valid bits LOG_N cycles earlier.
- R9: An element holding two packets that request different outputs passes both, in the straight or crossed setting. For N=8, the identity and the reversal permutations are delivered in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Packet present on each input |
| in_dest | input | N*LOG_N | Destination port per input, input i at bits [i*LOG_N +: LOG_N] |
| in_data | input | N*DATA_W | Payload per input, input i at bits [i*DATA_W +: DATA_W] |
| out_valid | output | N | Packet delivered on each output port |
| out_dest | output | N*LOG_N | Destination field carried by each delivered packet |
| out_data | output | N*DATA_W | Payload of each delivered packet |
| out_drop | output | N | Per input port: its packet of this slot was discarded |

## Verification
The bench covers full permutations that the network can route and permutations that it blocks. It covers many-to-one hot spots on the lowest and the highest port, straight and crossed elements, and all 64 single-packet paths. A design that swapped the winning input, or that used the tag bits in the wrong order, would deliver the wrong survivor or block the permutations that should pass. A one-bit error in the shuffle direction would land packets on the wrong port. A drop vector that was not aligned to the output slot would break the per-slot conservation count. A reset that arrives while packets are in flight must flush them. Injecting one packet into an empty fabric pins the latency to exactly LOG_N cycles.

// File: rtl/shuffle_fabric.sv
module shuffle_fabric #(
  parameter int LOG_N  = 3,
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [(1<<LOG_N)-1:0]             in_valid,
  input  logic [(1<<LOG_N)*LOG_N-1:0]       in_dest,
  input  logic [(1<<LOG_N)*DATA_W-1:0]      in_data,
  output logic [(1<<LOG_N)-1:0]             out_valid,
  output logic [(1<<LOG_N)*LOG_N-1:0]       out_dest,
  output logic [(1<<LOG_N)*DATA_W-1:0]      out_data,
  output logic [(1<<LOG_N)-1:0]             out_drop
);
  localparam int N    = 1 << LOG_N;
  localparam int HALF = N / 2;

  function automatic logic steer(input logic [LOG_N-1:0] d, input int st);
    logic [LOG_N-1:0] tag;
    for (int b = 0; b < LOG_N; b++) tag[b] = d[LOG_N-1-b];
    return tag[st];
  endfunction

  genvar s, j;
  for (s = 0; s < LOG_N; s++) begin : g_stage
    logic [N-1:0]        iv, bit_lo, take_lo, nv, vq, idrop, nd, dq;
    logic [LOG_N-1:0]    idst [N];
    logic [LOG_N-1:0]    ndst [N];
    logic [LOG_N-1:0]    dstq [N];
    logic [LOG_N-1:0]    isrc [N];
    logic [DATA_W-1:0]   idat [N];
    logic [DATA_W-1:0]   ndat [N];
    logic [DATA_W-1:0]   datq [N];

    for (j = 0; j < N; j++) begin : g_wire
      localparam int SRC = (j >> 1) | ((j & 1) << (LOG_N - 1));
      localparam int UP  = (j / 2) * 2;
      if (s == 0) begin : g_in
        assign iv[j]   = in_valid[SRC];
        assign idst[j] = in_dest[SRC*LOG_N +: LOG_N];
        assign idat[j] = in_data[SRC*DATA_W +: DATA_W];
        assign isrc[j] = LOG_N'(SRC);
      end else begin : g_link
        assign iv[j]   = g_stage[s-1].vq[SRC];
        assign idst[j] = g_stage[s-1].dstq[SRC];
        assign idat[j] = g_stage[s-1].datq[SRC];
        assign isrc[j] = g_stage[s-1].g_src.srcq[SRC];
      end
      assign bit_lo[j] = steer(idst[j], s);
      assign ndst[j]   = take_lo[j] ? idst[UP+1] : idst[UP];
      assign ndat[j]   = take_lo[j] ? idat[UP+1] : idat[UP];
    end

    if (s == 0) begin : g_drop_first
      assign idrop = '0;
    end else begin : g_drop_link
      assign idrop = g_stage[s-1].dq;
    end

    always_comb begin
      nd = idrop;
      for (int e = 0; e < HALF; e++) begin
        take_lo[2*e]   = !(iv[2*e] && !bit_lo[2*e]);
        take_lo[2*e+1] = !(iv[2*e] &&  bit_lo[2*e]);
        nv[2*e]   = (iv[2*e] && !bit_lo[2*e]) || (iv[2*e+1] && !bit_lo[2*e+1]);
        nv[2*e+1] = (iv[2*e] &&  bit_lo[2*e]) || (iv[2*e+1] &&  bit_lo[2*e+1]);
        if (iv[2*e] && iv[2*e+1] && (bit_lo[2*e] == bit_lo[2*e+1]))
          nd[isrc[2*e+1]] = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vq <= '0;
        dq <= '0;
      end else begin
        vq <= nv;
        dq <= nd;
      end
    end

    always_ff @(posedge clk) begin
      dstq <= ndst;
      datq <= ndat;
    end

    if (s < LOG_N - 1) begin : g_src
      logic [LOG_N-1:0] nsrc [N];
      logic [LOG_N-1:0] srcq [N];
      for (j = 0; j < N; j++) begin : g_sel
        localparam int UP = (j / 2) * 2;
        assign nsrc[j] = take_lo[j] ? isrc[UP+1] : isrc[UP];
      end
      always_ff @(posedge clk) srcq <= nsrc;
    end
  end

  assign out_valid = g_stage[LOG_N-1].vq;
  assign out_drop  = g_stage[LOG_N-1].dq;
  for (j = 0; j < N; j++) begin : g_out
    assign out_dest[j*LOG_N +: LOG_N]   = g_stage[LOG_N-1].dstq[j];
    assign out_data[j*DATA_W +: DATA_W] = g_stage[LOG_N-1].datq[j];
  end
endmodule

// File: rtl/fabric_checker.sv
module fabric_checker #(
  parameter int LOG_N = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [(1<<LOG_N)-1:0]       in_valid,
  input logic [(1<<LOG_N)-1:0]       out_valid,
  input logic [(1<<LOG_N)*LOG_N-1:0] out_dest,
  input logic [(1<<LOG_N)-1:0]       out_drop
);
  localparam int N = 1 << LOG_N;

  int unsigned since_rst;
  logic        warm;

  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= 0;
    else if (since_rst < LOG_N) since_rst <= since_rst + 1;
  end
  assign warm = since_rst >= LOG_N;

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (out_valid == '0 && out_drop == '0)); // R1

  AST_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> ($countones(out_valid) + $countones(out_drop) ==
              $past($countones(in_valid), LOG_N))); // R8

  AST_LONE_DELIVERED: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past($countones(in_valid), LOG_N) == 1) |->
      ($countones(out_valid) == 1 && out_drop == '0)); // R5

  genvar j;
  for (j = 0; j < N; j++) begin : g_port
    AST_PORT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[j] |-> out_dest[j*LOG_N +: LOG_N] == LOG_N'(j)); // R3
    AST_DROP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_drop[j]) |-> $past(in_valid[j], LOG_N)); // R7
  end
endmodule

bind shuffle_fabric fabric_checker #(.LOG_N(LOG_N)) u_fabric_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_dest(out_dest), .out_drop(out_drop)
);

// File: tb/test_shuffle_fabric.sv
module test_shuffle_fabric;
  localparam int CLK_PERIOD = 10;
  localparam int LOG_N = 3;
  localparam int N     = 8;
  localparam int DW    = 8;
  localparam int NTAB  = 10;
  localparam int NVEC  = NTAB + N * N;

  // {in_valid, dests (input 0 in low bits), expected out_valid, expected out_drop}
  localparam logic [47:0] TAB [NTAB] = '{
    48'hFF_FAC688_FF_00,  // R9 identity
    48'hFF_053977_FF_00,  // R9 reversal
    48'hFF_000000_01_FE,  // R6 hot spot on port 0
    48'hFF_FFFFFF_80_FE,  // R6 hot spot on port 7
    48'h20_030000_40_00,  // R5 input 5 to port 6
    48'h11_003003_08_10,  // R6 R7 inputs 0 and 4 to port 3
    48'h03_000008_03_00,  // R9 straight element
    48'h11_000004_11_00,  // R9 crossed element
    48'h05_000040_01_04,  // R4 internal blocking
    48'h00_000000_00_00   // idle slot
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      in_valid = '0;
  logic [N*LOG_N-1:0] in_dest = '0;
  logic [N*DW-1:0]   in_data = '0;
  logic [N-1:0]      out_valid, out_drop;
  logic [N*LOG_N-1:0] out_dest;
  logic [N*DW-1:0]   out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  shuffle_fabric #(.LOG_N(LOG_N), .DATA_W(DW)) i_shuffle_fabric (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_valid(out_valid), .out_dest(out_dest),
    .out_data(out_data), .out_drop(out_drop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [47:0] vec(input int i);
    logic [23:0] dd;
    int k, src, dst;
    if (i < NTAB) return TAB[i];
    k = i - NTAB; src = k / N; dst = k % N;
    for (int b = 0; b < N; b++) dd[b*3 +: 3] = 3'(dst);
    return {8'(1 << src), dd, 8'(1 << dst), 8'h00};
  endfunction

  function automatic logic [DW-1:0] pay(input int slot, input int j);
    return DW'(slot * 8 + j);
  endfunction

  task automatic drive(input int slot);
    logic [47:0] v;
    v = vec(slot);
    in_valid = v[47:40];
    in_dest  = v[39:16];
    for (int j = 0; j < N; j++) in_data[j*DW +: DW] = pay(slot, j);
  endtask

  task automatic idle();
    in_valid = '0;
    in_dest  = '0;
    in_data  = '0;
  endtask

  task automatic check_slot(input int slot);
    logic [47:0] v;
    logic found;
    v = vec(slot);
    chk($sformatf("R2 R4 R5 R6 R9 out_valid slot %0d", slot), 32'(out_valid), 32'(v[15:8]));
    chk($sformatf("R7 out_drop slot %0d", slot), 32'(out_drop), 32'(v[7:0]));
    chk($sformatf("R8 conservation slot %0d", slot),
        32'($countones(out_valid) + $countones(out_drop)), 32'($countones(v[47:40])));
    for (int p = 0; p < N; p++) begin
      if (out_valid[p]) begin
        chk($sformatf("R3 dest field port %0d slot %0d", p, slot),
            32'(out_dest[p*3 +: 3]), 32'(p));
        found = 1'b0;
        for (int j = 0; j < N; j++)
          if (v[40+j] && v[16+j*3 +: 3] == 3'(p) && !v[j] &&
              out_data[p*DW +: DW] == pay(slot, j)) found = 1'b1;
        chk($sformatf("R3 payload match port %0d slot %0d", p, slot), 32'(found), 32'd1);
      end
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: inputs busy while reset is held
    in_valid = '1;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
    chk("R1 out_drop in reset", 32'(out_drop), 32'd0);
    idle();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after release", 32'(out_valid), 32'd0);

    // R2: one packet, exact latency (input 3 to port 5)
    @(negedge clk);
    drive(NTAB + 3 * N + 5);
    @(negedge clk); idle();
    chk("R2 early cycle 1", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk("R2 early cycle 2", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk("R2 arrival", 32'(out_valid), 32'h20);
    chk("R3 lone payload", 32'(out_data[5*DW +: DW]), 32'(pay(NTAB + 3 * N + 5, 3)));
    @(negedge clk);
    chk("R2 gone after one cycle", 32'(out_valid), 32'd0);

    // Back-to-back table and all single paths
    for (int c = 0; c < NVEC + LOG_N; c++) begin
      @(negedge clk);
      if (c >= LOG_N) check_slot(c - LOG_N);
      if (c < NVEC) drive(c); else idle();
    end

    // R1: reset flushes packets in flight
    @(negedge clk); drive(0);
    @(negedge clk); idle();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 flush out_valid", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    for (int k = 0; k < LOG_N + 1; k++) begin
      @(negedge clk);
      chk("R1 no stale packet", 32'({out_valid, out_drop}), 32'd0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule